// File: doc/BRIEF.md
# DMA Physical Address Extender

This block widens the 16-bit addresses of an 8-bit DMA controller into 20-bit physical addresses, so that DMA can reach a 1 MB memory space. Each DMA address is built from three parts:

- **Low byte.** It passes straight through from the controller's address pins.
- **Middle byte.** The controller places it on its data bus at the start of a transfer and marks it with an address strobe. The block keeps this byte in a register.
- **Top nibble.** Software writes it into a page register at I/O port 50h.

Because the page does not change during a block transfer, one block stays inside a single 64 KB page.

The address output is gated by the controller's DMA-enable signal. While DMA is not active, the output reads zero and the valid flag is low. This lets the system address multiplexer tell DMA cycles from CPU cycles.

Top module: `dma_addr_extender`

## Requirements
- R1: While `rst_n` is low, the middle-byte register and the page register are cleared to zero. After reset, with DMA enabled, the output reads `{4'h0, 8'h00, dma_lo}`.
- R2: Output bits 7:0 follow `dma_lo` combinationally, with no clock delay, while `dma_en` is high.
- R3: On each rising clock edge at which `addr_stb` is high, output bits 15:8 take the value of `dma_data`.
- R4: While `addr_stb` is low, the middle byte keeps its value, whatever happens on `dma_data`.
- R5: Output bits 19:16 load `io_wdata` at the first rising clock edge at which `io_wr` is high (it was low at the previous edge) and `io_addr` equals 8'h50.
- R6: An I/O write to any port other than 8'h50 leaves the page register unchanged.
- R7: If `io_wr` stays high for several cycles, only its first edge loads the page. Later changes of `io_wdata` during the same write have no effect.
- R8: While `dma_en` is low, `phys_addr` is 20'h00000.
- R9: `addr_valid` equals `dma_en` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_lo | input | 8 | Low address byte from the DMA controller |
| dma_data | input | 8 | DMA controller data bus, carrying the middle address byte |
| addr_stb | input | 1 | Address strobe; captures `dma_data` while high |
| dma_en | input | 1 | DMA active; enables the address output |
| io_wr | input | 1 | CPU I/O write strobe |
| io_addr | input | 8 | CPU I/O port address |
| io_wdata | input | 4 | CPU I/O write data for the page nibble |
| phys_addr | output | 20 | 20-bit physical DMA address, zero when idle |
| addr_valid | output | 1 | High while `phys_addr` carries a DMA address |

## Verification
The bench goes after the following corner cases:

- **Data bus after the strobe falls.** It changes `dma_data` after the strobe has dropped. A latch that stays transparent would follow the data bus and corrupt the middle byte in the middle of a block.
- **Long write strobe.** It holds `io_wr` high over several cycles while the write data changes. A design that loads on the level instead of the edge would end with the last nibble, not the first.
- **Write to a neighbouring port.** It writes to port 51h. A design with an incomplete address decode would change the page.
- **Idle gating.** It toggles `dma_en` with non-zero latches. A design with missing gating would leak a stale address onto the bus during CPU cycles.

// File: rtl/dma_addr_extender.sv
module dma_addr_extender #(
  parameter int          LO_W      = 8,
  parameter int          MID_W     = 8,
  parameter int          PAGE_W    = 4,
  parameter int          IO_AW     = 8,
  parameter logic [7:0]  PAGE_PORT = 8'h50
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LO_W-1:0]               dma_lo,
  input  logic [MID_W-1:0]              dma_data,
  input  logic                          addr_stb,
  input  logic                          dma_en,
  input  logic                          io_wr,
  input  logic [IO_AW-1:0]              io_addr,
  input  logic [PAGE_W-1:0]             io_wdata,
  output logic [LO_W+MID_W+PAGE_W-1:0]  phys_addr,
  output logic                          addr_valid
);

  localparam int AW = LO_W + MID_W + PAGE_W;

  logic [MID_W-1:0]  mid_q;
  logic [PAGE_W-1:0] page_q;
  logic              wr_q;
  logic              page_we;

  assign page_we = io_wr && !wr_q && (io_addr == IO_AW'(PAGE_PORT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid_q  <= '0;
      page_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      wr_q <= io_wr;
      if (addr_stb) mid_q  <= dma_data;
      if (page_we)  page_q <= io_wdata;
    end
  end

  assign addr_valid = dma_en;
  assign phys_addr  = dma_en ? {page_q, mid_q, dma_lo} : AW'(0);

  // R1
  always_ff @(posedge clk) begin
    if (rst_n && !$past(rst_n)) begin
      reset_clear_chk: assert (mid_q == '0 && page_q == '0);
    end
  end

  // R3
  mid_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |=> mid_q == $past(dma_data));

  // R4
  mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_stb |=> $stable(mid_q));

  // R5
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !wr_q && io_addr == IO_AW'(PAGE_PORT)) |=> page_q == $past(io_wdata));

  // R6
  page_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr != IO_AW'(PAGE_PORT)) |=> $stable(page_q));

  // R7
  page_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && wr_q) |=> $stable(page_q));

endmodule

// File: tb/sim_dma_addr_extender.sv
module sim_dma_addr_extender;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  dma_lo = '0;
  logic [7:0]  dma_data = '0;
  logic        addr_stb = 1'b0;
  logic        dma_en = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_addr = '0;
  logic [3:0]  io_wdata = '0;
  logic [19:0] phys_addr;
  logic        addr_valid;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference state
  int ref_mid = 0;
  int ref_page = 0;
  bit ref_wr_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_extender u0 (
    .clk(clk), .rst_n(rst_n), .dma_lo(dma_lo), .dma_data(dma_data),
    .addr_stb(addr_stb), .dma_en(dma_en), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .phys_addr(phys_addr), .addr_valid(addr_valid)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_mid = 0; ref_page = 0; ref_wr_prev = 0;
    end else begin
      if (addr_stb) ref_mid = dma_data;
      if (io_wr && !ref_wr_prev && io_addr == 8'h50) ref_page = io_wdata;
      ref_wr_prev = io_wr;
    end
  end

  task automatic check(input string tag, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, actual, expected);
    end
  endtask

  // per-cycle comparison against the reference (R2, R8, R9)
  always @(negedge clk) begin
    if (!done) begin
      int exp_addr;
      exp_addr = dma_en ? ((ref_page << 16) | (ref_mid << 8) | dma_lo) : 0;
      check("R2/R8 cycle", phys_addr, exp_addr);
      check("R9 cycle", addr_valid, dma_en);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic at_neg();
    @(negedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    dma_en = 1'b1; dma_lo = 8'hAB; dma_data = 8'h5A; addr_stb = 1'b1;
    repeat (3) step();
    at_neg();
    check("R1 reset value", phys_addr, 20'h000AB);
    step(); rst_n = 1'b1; addr_stb = 1'b0; dma_data = 8'h00;
    step();
    at_neg();
    check("R1 after release", phys_addr, 20'h000AB);

    step(); dma_en = 1'b0;
    at_neg();
    check("R8 idle zero", phys_addr, 0);
    check("R9 idle valid", addr_valid, 0);

    step(); io_addr = 8'h50; io_wdata = 4'h7; io_wr = 1'b1;
    step(); io_wr = 1'b0; io_wdata = 4'h0;
    step(); dma_en = 1'b1; dma_lo = 8'h12;
    at_neg();
    check("R5 page load", phys_addr, 20'h70012);
    check("R9 active valid", addr_valid, 1);

    step(); addr_stb = 1'b1; dma_data = 8'h34;
    step(); addr_stb = 1'b0; dma_data = 8'h99;
    at_neg();
    check("R3 mid capture", phys_addr, 20'h73412);
    step(); dma_data = 8'hC3;
    step();
    at_neg();
    check("R4 mid hold", phys_addr, 20'h73412);

    dma_lo = 8'hFE; #1;
    check("R2 low pass", phys_addr, 20'h734FE);

    step(); io_addr = 8'h51; io_wdata = 4'hA; io_wr = 1'b1;
    step(); io_wr = 1'b0;
    step();
    at_neg();
    check("R6 other port", phys_addr, 20'h734FE);

    step(); io_addr = 8'h50; io_wdata = 4'h3; io_wr = 1'b1;
    step(); io_wdata = 4'hC;
    step(); step();
    at_neg();
    check("R7 held write", phys_addr, 20'h334FE);
    step(); io_wr = 1'b0;
    step();
    at_neg();
    check("R7 after release", phys_addr, 20'h334FE);

    step(); addr_stb = 1'b1; dma_data = 8'h01;
    step(); dma_data = 8'h02;
    step(); addr_stb = 1'b0; dma_data = 8'hFF;
    at_neg();
    check("R3 last strobe cycle", phys_addr, 20'h302FE);

    step(); dma_en = 1'b0;
    at_neg();
    check("R8 stale gated", phys_addr, 0);
    step(); dma_en = 1'b1;
    at_neg();
    check("R9 returns", addr_valid, 1);

    step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule